// File: doc/BRIEF.md
# Sleep-Mode Interrupt Capture Controller

This block watches a bank of interrupt lines while the main interrupt distributor sleeps or is powered off. Every line has three programmable attributes: a mask, a polarity and a sensitivity (edge or level). When a line sees a qualifying event, the block latches it into a per-line pending bit, so that software can replay the events into the main controller after wake-up. Capture runs only while a global enable bit is set.

Software programs the block through a small word-addressed register port. Every attribute has a read-back word, a write-one-to-set alias and a write-one-to-clear alias. A status bank shows the pending bits and an acknowledge bank clears them. A control word holds the enable bit and a self-clearing soft-reset bit, which recovers the block when its state was corrupted by power loss. A summary interrupt output is high while any unmasked pending bit is set and the block is enabled.

Top module: `wake_capture_ctrl`

## Requirements
- R1: Line n maps to bit (n mod 32) of word (n div 32) in every per-line bank. There are NUM_WORDS words of 32 lines each.
- R2: Writing a 1 to a bit of a set alias sets that attribute bit, and writing a 1 to a bit of a clear alias clears it. Bits written 0 keep their value. The read-back bank returns the current value. For mask, 1 means masked. For polarity, 1 means active-high or rising. For sensitivity, 1 means level and 0 means edge.
- R3: After reset every mask bit is 1 and every polarity, sensitivity and pending bit is 0. The control word reads 0 and irq_out is 0.
- R4: A line in edge mode sets its pending bit once, on the selected transition of its two-flop synchronised input: rising when polarity is 1, falling when it is 0. The opposite transition sets nothing.
- R5: A line in level mode sets its pending bit while its synchronised input equals its polarity. An acknowledge does not clear the bit while that level persists. The bit stays set after the level goes away, until it is acknowledged.
- R6: A masked line never sets its pending bit.
- R7: While control bit 0 (enable) is 0, no pending bit is set.
- R8: A write to the acknowledge word clears the pending bit of every line whose written bit is 1. All other pending bits are unchanged.
- R9: Writing 1 to control bit 1 (soft reset) restores the R3 values of mask, polarity, sensitivity and pending one cycle later. The enable bit is kept. Bit 1 reads 1 for that single cycle only.
- R10: irq_out is 1 exactly when enable is 1 and some pending line is unmasked.
- R11: The register address is {bank[3:0], word[WORD_BITS-1:0]}. The bank codes are: 0 control, 1 mask, 2 mask set, 3 mask clear, 4 polarity, 5 polarity set, 6 polarity clear, 7 sensitivity, 8 sensitivity set, 9 sensitivity clear, 10 status, 11 acknowledge. Reads of alias and acknowledge banks return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4+WORD_BITS | Register address {bank, word} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| line_in | input | 32*NUM_WORDS | Asynchronous interrupt lines |
| irq_out | output | 1 | Summary interrupt |

## Verification
The bench aims at a level line that software acknowledges while the line is still active. A design that cleared the bit anyway would lose a wake event. It also drives the transition opposite to the programmed polarity, which a detector that fires on any change would wrongly capture. Masked and disabled periods are checked for silence. Soft reset is checked for restoring all configuration while keeping the enable bit; a design that dropped enable or left stale pending bits would show it in the read-back. Random traffic mixes alias writes with line toggles, which exposes an alias that disturbs its zero bits or a bit that is decoded into the wrong word.

// File: rtl/wcc_pkg.sv
// Package: bank codes of the capture controller register port.
// Assumes: bank code occupies the upper 4 address bits.
package wcc_pkg;
    localparam logic [3:0] BK_CTRL     = 4'd0;
    localparam logic [3:0] BK_MASK     = 4'd1;
    localparam logic [3:0] BK_MASK_SET = 4'd2;
    localparam logic [3:0] BK_MASK_CLR = 4'd3;
    localparam logic [3:0] BK_POL      = 4'd4;
    localparam logic [3:0] BK_POL_SET  = 4'd5;
    localparam logic [3:0] BK_POL_CLR  = 4'd6;
    localparam logic [3:0] BK_SENS     = 4'd7;
    localparam logic [3:0] BK_SENS_SET = 4'd8;
    localparam logic [3:0] BK_SENS_CLR = 4'd9;
    localparam logic [3:0] BK_STAT     = 4'd10;
    localparam logic [3:0] BK_ACK      = 4'd11;
    localparam int         WORD_W      = 32;
endpackage

// File: rtl/wcc_sync.sv
// Module: two-flop synchroniser per line, plus one history flop for edge detection.
// Assumes: lines are asynchronous level signals; reset value 0.
module wcc_sync #(
    parameter int LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_q,
    output logic [LINES-1:0] prev_q
);
    logic [LINES-1:0] meta_q;

    // Purpose: shift raw lines through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/wcc_cfg.sv
// Module: per-line mask/polarity/sensitivity banks, control word, ack decode.
// Assumes: word-addressed writes, set/clear aliases act only on 1 bits,
//          soft reset is a one-cycle registered pulse.
module wcc_cfg
    import wcc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int WORD_BITS = 4,
    localparam int LINES    = WORD_W * NUM_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [3:0]           bank,
    input  logic [WORD_BITS-1:0] word,
    input  logic [WORD_W-1:0]    wdata,
    output logic [LINES-1:0]     mask_q,
    output logic [LINES-1:0]     pol_q,
    output logic [LINES-1:0]     sens_q,
    output logic [LINES-1:0]     ack_vec,
    output logic                 en_q,
    output logic                 srst_q
);
    logic [WORD_W-1:0] mask_w [NUM_WORDS];
    logic [WORD_W-1:0] pol_w  [NUM_WORDS];
    logic [WORD_W-1:0] sens_w [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = wr && (word == WORD_BITS'(w));

        // Purpose: apply set/clear aliases to this word's attribute bits.
        always_ff @(posedge clk) begin
            if (!rst_n || srst_q) begin
                mask_w[w] <= '1;
                pol_w[w]  <= '0;
                sens_w[w] <= '0;
            end else if (hit) begin
                case (bank)
                    BK_MASK_SET: mask_w[w] <= mask_w[w] | wdata;
                    BK_MASK_CLR: mask_w[w] <= mask_w[w] & ~wdata;
                    BK_POL_SET:  pol_w[w]  <= pol_w[w]  | wdata;
                    BK_POL_CLR:  pol_w[w]  <= pol_w[w]  & ~wdata;
                    BK_SENS_SET: sens_w[w] <= sens_w[w] | wdata;
                    BK_SENS_CLR: sens_w[w] <= sens_w[w] & ~wdata;
                    default: ;
                endcase
            end
        end

        assign mask_q[w*WORD_W +: WORD_W]  = mask_w[w];
        assign pol_q[w*WORD_W +: WORD_W]   = pol_w[w];
        assign sens_q[w*WORD_W +: WORD_W]  = sens_w[w];
        assign ack_vec[w*WORD_W +: WORD_W] = (hit && bank == BK_ACK) ? wdata : '0;
    end

    // Purpose: hold the enable bit and generate the one-cycle soft reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= wr && (bank == BK_CTRL) && wdata[1] && !srst_q;
            if (wr && bank == BK_CTRL)
                en_q <= wdata[0];
        end
    end

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q); // R9
    AST_SRST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> ((&mask_q) && (pol_q == '0) && (sens_q == '0))); // R9
endmodule

// File: rtl/wcc_pending.sv
// Module: per-line event qualification and pending latch.
// Assumes: inputs already synchronised; ack and set act on the same edge,
//          with set winning so an active level cannot be acknowledged away.
module wcc_pending #(
    parameter int LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] sync_q,
    input  logic [LINES-1:0] prev_q,
    input  logic [LINES-1:0] mask_q,
    input  logic [LINES-1:0] pol_q,
    input  logic [LINES-1:0] sens_q,
    input  logic [LINES-1:0] ack_vec,
    input  logic             en_q,
    input  logic             srst_q,
    output logic [LINES-1:0] pend_q
);
    logic [LINES-1:0] edge_hit, lvl_hit, set_vec;

    // Purpose: qualify each line by its mode, polarity, mask and the global enable.
    always_comb begin
        edge_hit = (pol_q & sync_q & ~prev_q) | (~pol_q & ~sync_q & prev_q);
        lvl_hit  = ~(sync_q ^ pol_q);
        set_vec  = ((sens_q & lvl_hit) | (~sens_q & edge_hit)) & ~mask_q & {LINES{en_q}};
    end

    // Purpose: latch qualified events, clear acknowledged bits, wipe on soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~ack_vec) | set_vec;
    end

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_q) |=> ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0)); // R6
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ((pend_q & ~$past(pend_q)) == '0)); // R7
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !srst_q) |=> ((~pend_q & $past(sens_q & ~mask_q & ~(sync_q ^ pol_q))) == '0)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_vec) |=> ((pend_q & $past(ack_vec & ~set_vec)) == '0)); // R8
endmodule

// File: rtl/wake_capture_ctrl.sv
// Module: top of the sleep-mode interrupt capture controller.
// Assumes: word-addressed register port {bank, word}, combinational read data,
//          32 lines per word, synchronous active-low reset.
module wake_capture_ctrl
    import wcc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int WORD_BITS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [3+WORD_BITS:0]      reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic [32*NUM_WORDS-1:0]   line_in,
    output logic                      irq_out
);
    localparam int LINES  = WORD_W * NUM_WORDS;
    localparam int ADDR_W = 4 + WORD_BITS;

    logic [3:0]           bank;
    logic [WORD_BITS-1:0] word;
    logic [LINES-1:0]     sync_q, prev_q, mask_q, pol_q, sens_q, ack_vec, pend_q;
    logic                 en_q, srst_q;

    assign bank = reg_addr[ADDR_W-1 -: 4];
    assign word = reg_addr[WORD_BITS-1:0];

    wcc_sync #(.LINES(LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(line_in), .sync_q(sync_q), .prev_q(prev_q)
    );

    wcc_cfg #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .bank(bank), .word(word),
        .wdata(reg_wdata), .mask_q(mask_q), .pol_q(pol_q), .sens_q(sens_q),
        .ack_vec(ack_vec), .en_q(en_q), .srst_q(srst_q)
    );

    wcc_pending #(.LINES(LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
        .mask_q(mask_q), .pol_q(pol_q), .sens_q(sens_q), .ack_vec(ack_vec),
        .en_q(en_q), .srst_q(srst_q), .pend_q(pend_q)
    );

    // Purpose: select the read-back word addressed by bank and word index.
    always_comb begin
        reg_rdata = '0;
        if (bank == BK_CTRL)
            reg_rdata = {30'd0, srst_q, en_q};
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word == WORD_BITS'(w)) begin
                case (bank)
                    BK_MASK: reg_rdata = mask_q[w*WORD_W +: WORD_W];
                    BK_POL:  reg_rdata = pol_q[w*WORD_W +: WORD_W];
                    BK_SENS: reg_rdata = sens_q[w*WORD_W +: WORD_W];
                    BK_STAT: reg_rdata = pend_q[w*WORD_W +: WORD_W];
                    default: ;
                endcase
            end
        end
    end

    // Purpose: summary interrupt from unmasked pending lines while enabled.
    assign irq_out = en_q && |(pend_q & ~mask_q);

    AST_IRQ_QUIET_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !irq_out); // R10
endmodule

// File: tb/sim_wake_capture_ctrl.sv
module sim_wake_capture_ctrl;
    localparam int NW = 2;
    localparam int NL = 32 * NW;
    localparam logic [3:0] B_CTRL = 4'd0, B_MASK = 4'd1, B_MSET = 4'd2, B_MCLR = 4'd3,
                           B_POL = 4'd4, B_PSET = 4'd5, B_PCLR = 4'd6, B_SENS = 4'd7,
                           B_SSET = 4'd8, B_SCLR = 4'd9, B_STAT = 4'd10, B_ACK = 4'd11;

    logic clk = 0, rst_n = 0, reg_wr = 0, irq_out;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic [NL-1:0] line_in = '0;

    logic [NL-1:0] m_mask, m_pol, m_sens, m_pend;
    logic          m_en;
    int            n_chk = 0, n_fail = 0;
    logic [31:0]   d;

    always #5 clk = ~clk;

    wake_capture_ctrl #(.NUM_WORDS(NW), .WORD_BITS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in), .irq_out(irq_out)
    );

    function automatic logic [NL-1:0] f_edge(input logic [NL-1:0] o, n, pol);
        return (pol & n & ~o) | (~pol & ~n & o);
    endfunction

    function automatic logic f_irq();
        return m_en && |(m_pend & ~m_mask);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] bk, input int wd, input logic [31:0] dat);
        @(negedge clk);
        reg_wr = 1; reg_addr = {bk, 4'(wd)}; reg_wdata = dat;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] bk, input int wd, output logic [31:0] dat);
        @(negedge clk);
        reg_addr = {bk, 4'(wd)};
        #1 dat = reg_rdata;
    endtask

    task automatic apply_levels();
        if (m_en) m_pend |= ~m_mask & m_sens & ~(line_in ^ m_pol);
    endtask

    task automatic do_wr(input logic [3:0] bk, input int wd, input logic [31:0] dat);
        wr(bk, wd, dat);
        case (bk)
            B_MSET: m_mask[wd*32 +: 32] |= dat;
            B_MCLR: m_mask[wd*32 +: 32] &= ~dat;
            B_PSET: m_pol[wd*32 +: 32]  |= dat;
            B_PCLR: m_pol[wd*32 +: 32]  &= ~dat;
            B_SSET: m_sens[wd*32 +: 32] |= dat;
            B_SCLR: m_sens[wd*32 +: 32] &= ~dat;
            B_ACK:  m_pend[wd*32 +: 32] &= ~dat;
            B_CTRL: begin
                m_en = dat[0];
                if (dat[1]) begin
                    m_mask = '1; m_pol = '0; m_sens = '0; m_pend = '0;
                end
            end
            default: ;
        endcase
        apply_levels();
        settle();
    endtask

    task automatic do_line(input logic [NL-1:0] nv);
        logic [NL-1:0] ov;
        ov = line_in;
        @(negedge clk);
        line_in = nv;
        if (m_en) m_pend |= f_edge(ov, nv, m_pol) & ~m_mask & ~m_sens;
        apply_levels();
        settle();
    endtask

    task automatic chk_model();
        for (int w = 0; w < NW; w++) begin
            rd(B_STAT, w, d);
            chk(d == m_pend[w*32 +: 32], "R1 R4 R5 R6 R7 R8 status", d, m_pend[w*32 +: 32]);
        end
        chk(irq_out == f_irq(), "R10 irq", 32'(irq_out), 32'(f_irq()));
    endtask

    task automatic chk_cfg();
        for (int w = 0; w < NW; w++) begin
            rd(B_MASK, w, d); chk(d == m_mask[w*32 +: 32], "R2 mask readback", d, m_mask[w*32 +: 32]);
            rd(B_POL, w, d);  chk(d == m_pol[w*32 +: 32],  "R2 pol readback",  d, m_pol[w*32 +: 32]);
            rd(B_SENS, w, d); chk(d == m_sens[w*32 +: 32], "R2 sens readback", d, m_sens[w*32 +: 32]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        logic [NL-1:0] flip;
        seed_v = $urandom(20240611);
        m_mask = '1; m_pol = '0; m_sens = '0; m_pend = '0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();

        // R3 reset state
        rd(B_CTRL, 0, d); chk(d == 32'h0, "R3 ctrl after reset", d, 32'h0);
        rd(B_MASK, 1, d); chk(d == 32'hFFFF_FFFF, "R3 mask after reset", d, 32'hFFFF_FFFF);
        rd(B_POL, 0, d);  chk(d == 32'h0, "R3 pol after reset", d, 32'h0);
        rd(B_SENS, 1, d); chk(d == 32'h0, "R3 sens after reset", d, 32'h0);
        rd(B_STAT, 0, d); chk(d == 32'h0, "R3 status after reset", d, 32'h0);
        chk(irq_out == 1'b0, "R3 irq after reset", 32'(irq_out), 32'h0);

        // R2 aliases touch only the 1 bits; R11 alias reads return 0
        do_wr(B_MCLR, 0, 32'h0000_00F0);
        rd(B_MASK, 0, d); chk(d == 32'hFFFF_FF0F, "R2 mask clear alias", d, 32'hFFFF_FF0F);
        do_wr(B_MSET, 0, 32'h0000_0010);
        rd(B_MASK, 0, d); chk(d == 32'hFFFF_FF1F, "R2 mask set alias", d, 32'hFFFF_FF1F);
        rd(B_MSET, 0, d); chk(d == 32'h0, "R11 alias bank reads zero", d, 32'h0);

        // R1 R4 line 37 -> word 1 bit 5, rising edge capture
        do_wr(B_MCLR, 1, 32'h20);
        do_wr(B_PSET, 1, 32'h20);
        do_wr(B_CTRL, 0, 32'h1);
        do_line(line_in | (64'd1 << 37));
        rd(B_STAT, 1, d); chk(d == 32'h20, "R1 R4 line 37 rising captured", d, 32'h20);
        rd(B_STAT, 0, d); chk(d == 32'h0, "R1 word 0 untouched", d, 32'h0);
        chk(irq_out == 1'b1, "R10 irq with unmasked pending", 32'(irq_out), 32'h1);
        do_wr(B_ACK, 1, 32'h20);
        rd(B_STAT, 1, d); chk(d == 32'h0, "R8 ack clears edge pending", d, 32'h0);
        chk(irq_out == 1'b0, "R10 irq drops after ack", 32'(irq_out), 32'h0);
        do_line(line_in & ~(64'd1 << 37));
        rd(B_STAT, 1, d); chk(d == 32'h0, "R4 falling ignored with rising polarity", d, 32'h0);

        // R6 masked line 0
        do_wr(B_PSET, 0, 32'h1);
        do_line(line_in | 64'd1);
        rd(B_STAT, 0, d); chk(d == 32'h0, "R6 masked line no pending", d, 32'h0);

        // R7 disabled
        do_wr(B_CTRL, 0, 32'h0);
        do_line(line_in | (64'd1 << 37));
        rd(B_STAT, 1, d); chk(d == 32'h0, "R7 no capture while disabled", d, 32'h0);
        do_line(line_in & ~(64'd1 << 37));
        do_wr(B_CTRL, 0, 32'h1);

        // R5 level mode, active low on line 5
        do_wr(B_SSET, 0, 32'h20);
        rd(B_STAT, 0, d); chk(d == 32'h20, "R5 active level sets pending", d, 32'h20);
        do_wr(B_ACK, 0, 32'h20);
        rd(B_STAT, 0, d); chk(d == 32'h20, "R5 ack ignored while level active", d, 32'h20);
        do_line(line_in | (64'd1 << 5));
        rd(B_STAT, 0, d); chk(d == 32'h20, "R5 pending held after level ends", d, 32'h20);
        do_wr(B_ACK, 0, 32'h20);
        rd(B_STAT, 0, d); chk(d == 32'h0, "R5 ack clears after level ends", d, 32'h0);

        // R9 soft reset
        do_wr(B_CTRL, 0, 32'h3);
        rd(B_CTRL, 0, d); chk(d == 32'h1, "R9 srst self-clears and enable kept", d, 32'h1);
        rd(B_MASK, 0, d); chk(d == 32'hFFFF_FFFF, "R9 mask restored", d, 32'hFFFF_FFFF);
        rd(B_POL, 1, d);  chk(d == 32'h0, "R9 pol restored", d, 32'h0);
        rd(B_SENS, 0, d); chk(d == 32'h0, "R9 sens restored", d, 32'h0);
        chk_model();

        // Random mix checked against the bench model
        for (int s = 0; s < 400; s++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                flip = {$urandom() & $urandom() & $urandom(), $urandom() & $urandom() & $urandom()};
                do_line(line_in ^ flip);
            end else begin
                int wd;
                logic [3:0] bk;
                logic [31:0] dat;
                wd = int'($urandom_range(0, NW - 1));
                dat = $urandom();
                case ($urandom_range(0, 7))
                    0: bk = B_MSET;
                    1: bk = B_MCLR;
                    2: bk = B_PSET;
                    3: bk = B_PCLR;
                    4: bk = B_SSET;
                    5: bk = B_SCLR;
                    6: bk = B_ACK;
                    default: begin
                        bk = B_CTRL;
                        dat = {30'd0, ($urandom_range(0, 19) == 0), ($urandom_range(0, 4) != 0)};
                    end
                endcase
                do_wr(bk, wd, dat);
            end
            chk_model();
            if (s % 20 == 0) chk_cfg();
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule